// File: doc/BRIEF.md
# Indexed Display Register Port

This block is the byte-wide register front end of a VGA-style display controller. A host issues single-byte reads and writes at small offsets. Three index/data port pairs reach three register banks: timing control, sequencing and graphics control. Writing an index port selects a register in its bank. Accessing the matching data port then reads or writes that register. Reads return their data one cycle after the access.

A palette mask port sits at offset 0x06. The same port also leads to a hidden pixel-format byte. The host must read the mask port at least four times in a row; the next write to that port then lands in the hidden byte instead of the mask. Any other access disarms this sequence. The pixel depth code in sequencer register 7 is decoded into a format number. A consistency flag reports whether the hidden byte matches that depth. Both are sent to the downstream display pipe.

Top module: `disp_regport`

## Requirements
- R1: After reset, every index latch and every bank register is 0x00, the hidden format byte is 0x00, the mask is 0xFF, the read data is 0x00 and the unlock count is zero.
- R2: A write to an index port (sequencer 0x04, graphics 0x0E, CRT 0x14) stores the full byte. A read of that port returns the stored byte.
- R3: Sequencer data port 0x05 reads and writes the sequencer register selected by the sequencer index (32 registers).
- R4: CRT data port 0x15 reads and writes the CRT register selected by the CRT index (64 registers).
- R5: Graphics data port 0x0F reads and writes the graphics register selected by the graphics index (16 registers).
- R6: When an index is at or beyond its bank's depth, a data write has no effect on any register and a data read returns 0x00.
- R7: A read of offset 0x06 returns the mask. A write to 0x06 updates the mask when the unlock is not armed.
- R8: After at least four consecutive reads of 0x06, the next write to 0x06 updates the hidden format byte and leaves the mask unchanged. Further reads past four keep the unlock armed.
- R9: Any access other than a read of 0x06 clears the unlock count. This includes a write to 0x06, whether it was armed or not, and accesses to unmapped offsets.
- R10: pix_fmt_o decodes the low five bits of sequencer register 7 and ignores the upper three: 0x11→1 (8 bpp indexed), 0x17→2 (16 bpp 5-6-5), 0x15→3 (24 bpp), 0x19→4 (32 bpp), any other code→0.
- R11: fmt_ok_o is 1 exactly when pix_fmt_o is nonzero and the hidden byte equals 0x00 for format 1, 0xC1 for format 2, or 0xC5 for formats 3 and 4.
- R12: Reads of offsets that map to no port return 0x00. Writes to them change no state.
- R13: bus_rdata_o is updated only at the edge that takes a read. It holds its value through every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_en_i | input | 1 | Access strobe, one access per cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 5 | Byte offset |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, registered |
| pix_fmt_o | output | 3 | Decoded pixel format number |
| hidden_fmt_o | output | 8 | Hidden pixel-format byte |
| pix_mask_o | output | 8 | Palette mask |
| fmt_ok_o | output | 1 | Hidden byte agrees with the depth code |

## Verification
Each access is taken at a rising edge. Read data appears at bus_rdata_o during the cycle after that edge. Register writes reach pix_fmt_o, hidden_fmt_o, pix_mask_o and fmt_ok_o during that same following cycle. The unlock count changes at the same edge, so an armed write is honoured on the access right after the fourth read. The bench drives an access at the falling edge and lets the rising edge take it. It then advances its behavioural model and compares every output at the next falling edge. This places each result exactly one edge after its stimulus, with no slack in either direction.

// File: rtl/regport_pkg.sv
package regport_pkg;

  localparam int ADDR_W = 5;
  localparam int DATA_W = 8;
  localparam int NUM_BANKS = 3;

  localparam logic [ADDR_W-1:0] OFS_SEQ_IDX = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_SEQ_DAT = 5'h05;
  localparam logic [ADDR_W-1:0] OFS_MASK    = 5'h06;
  localparam logic [ADDR_W-1:0] OFS_GFX_IDX = 5'h0E;
  localparam logic [ADDR_W-1:0] OFS_GFX_DAT = 5'h0F;
  localparam logic [ADDR_W-1:0] OFS_CRT_IDX = 5'h14;
  localparam logic [ADDR_W-1:0] OFS_CRT_DAT = 5'h15;

  // bank slots in the generate array
  localparam int BK_SEQ = 0;
  localparam int BK_GFX = 1;
  localparam int BK_CRT = 2;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_IDX,
    SEL_DAT,
    SEL_MASK
  } port_kind_e;

  typedef struct packed {
    port_kind_e kind;
    logic [1:0] bank;
  } port_sel_t;

  typedef enum logic [2:0] {
    FMT_NONE     = 3'd0,
    FMT_IDX8     = 3'd1,
    FMT_RGB16    = 3'd2,
    FMT_RGB24    = 3'd3,
    FMT_RGB32    = 3'd4
  } pix_fmt_e;

  function automatic pix_fmt_e depth_to_fmt(logic [4:0] code);
    case (code)
      5'h11:   return FMT_IDX8;
      5'h17:   return FMT_RGB16;
      5'h15:   return FMT_RGB24;
      5'h19:   return FMT_RGB32;
      default: return FMT_NONE;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] fmt_to_hidden(pix_fmt_e fmt);
    case (fmt)
      FMT_RGB16:           return 8'hC1;
      FMT_RGB24, FMT_RGB32: return 8'hC5;
      default:             return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/regport_decode.sv
module regport_decode
  import regport_pkg::*;
(
  input  logic              en_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output port_sel_t         sel_o,
  output logic              rd_o,
  output logic              wr_o
);

  always_comb begin
    sel_o = '{kind: SEL_NONE, bank: 2'd0};
    case (addr_i)
      OFS_SEQ_IDX: sel_o = '{kind: SEL_IDX,  bank: 2'(BK_SEQ)};
      OFS_SEQ_DAT: sel_o = '{kind: SEL_DAT,  bank: 2'(BK_SEQ)};
      OFS_GFX_IDX: sel_o = '{kind: SEL_IDX,  bank: 2'(BK_GFX)};
      OFS_GFX_DAT: sel_o = '{kind: SEL_DAT,  bank: 2'(BK_GFX)};
      OFS_CRT_IDX: sel_o = '{kind: SEL_IDX,  bank: 2'(BK_CRT)};
      OFS_CRT_DAT: sel_o = '{kind: SEL_DAT,  bank: 2'(BK_CRT)};
      OFS_MASK:    sel_o = '{kind: SEL_MASK, bank: 2'd0};
      default:     sel_o = '{kind: SEL_NONE, bank: 2'd0};
    endcase
  end

  assign rd_o = en_i && !we_i;
  assign wr_o = en_i && we_i;

endmodule

// File: rtl/regport_bank.sv
module regport_bank #(
  parameter int DEPTH   = 16,
  parameter int DW      = 8,
  parameter int TAP_IDX = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          idx_we_i,
  input  logic          dat_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] idx_o,
  output logic [DW-1:0] dat_o,
  output logic [DW-1:0] tap_o
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [DW:0] DEPTH_L = (DW+1)'(DEPTH);

  logic [DW-1:0] idx_q;
  logic [DW-1:0] mem_q [DEPTH];
  logic          in_range;
  logic [AW-1:0] slot;

  assign in_range = ({1'b0, idx_q} < DEPTH_L);
  assign slot     = idx_q[AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
    end else if (idx_we_i) begin
      idx_q <= wdata_i;
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_q[e] <= '0;
      end else if (dat_we_i && in_range && (slot == AW'(e))) begin
        mem_q[e] <= wdata_i;
      end
    end
  end

  assign idx_o = idx_q;
  assign dat_o = in_range ? mem_q[slot] : '0;
  assign tap_o = mem_q[TAP_IDX];

endmodule

// File: rtl/regport_unlock.sv
module regport_unlock #(
  parameter int READS = 4,
  parameter int CW    = $clog2(READS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mask_rd_i,
  input  logic          other_i,
  output logic          armed_o,
  output logic [CW-1:0] cnt_o
);

  localparam logic [CW-1:0] TOP = CW'(READS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (other_i) begin
      cnt_q <= '0;
    end else if (mask_rd_i && (cnt_q != TOP)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign armed_o = (cnt_q == TOP);
  assign cnt_o   = cnt_q;

endmodule

// File: rtl/disp_regport.sv
module disp_regport
  import regport_pkg::*;
#(
  parameter int          SEQ_DEPTH    = 32,
  parameter int          GFX_DEPTH    = 16,
  parameter int          CRT_DEPTH    = 64,
  parameter int          FMT_REG      = 7,
  parameter int          UNLOCK_READS = 4,
  parameter logic [7:0]  MASK_RST     = 8'hFF
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_en_i,
  input  logic        bus_we_i,
  input  logic [4:0]  bus_addr_i,
  input  logic [7:0]  bus_wdata_i,
  output logic [7:0]  bus_rdata_o,
  output logic [2:0]  pix_fmt_o,
  output logic [7:0]  hidden_fmt_o,
  output logic [7:0]  pix_mask_o,
  output logic        fmt_ok_o
);

  localparam int CNT_W = $clog2(UNLOCK_READS + 1);
  localparam int BANK_DEPTH [NUM_BANKS] = '{SEQ_DEPTH, GFX_DEPTH, CRT_DEPTH};

  port_sel_t        sel;
  logic             acc_rd, acc_wr;
  logic             mask_rd, mask_wr, other_acc;
  logic             armed;
  logic [CNT_W-1:0] unlock_cnt;

  logic [DATA_W-1:0] bank_idx [NUM_BANKS];
  logic [DATA_W-1:0] bank_dat [NUM_BANKS];
  logic [DATA_W-1:0] bank_tap [NUM_BANKS];
  logic              idx_we   [NUM_BANKS];
  logic              dat_we   [NUM_BANKS];

  logic [DATA_W-1:0] mask_q, hidden_q, rdata_q, rd_mux;
  pix_fmt_e          fmt;

  regport_decode u_decode (
    .en_i   (bus_en_i),
    .we_i   (bus_we_i),
    .addr_i (bus_addr_i),
    .sel_o  (sel),
    .rd_o   (acc_rd),
    .wr_o   (acc_wr)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign idx_we[b] = acc_wr && (sel.kind == SEL_IDX) && (sel.bank == 2'(b));
    assign dat_we[b] = acc_wr && (sel.kind == SEL_DAT) && (sel.bank == 2'(b));

    regport_bank #(
      .DEPTH   (BANK_DEPTH[b]),
      .DW      (DATA_W),
      .TAP_IDX ((b == BK_SEQ) ? FMT_REG : 0)
    ) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .idx_we_i (idx_we[b]),
      .dat_we_i (dat_we[b]),
      .wdata_i  (bus_wdata_i),
      .idx_o    (bank_idx[b]),
      .dat_o    (bank_dat[b]),
      .tap_o    (bank_tap[b])
    );
  end

  assign mask_rd   = acc_rd && (sel.kind == SEL_MASK);
  assign mask_wr   = acc_wr && (sel.kind == SEL_MASK);
  assign other_acc = bus_en_i && !mask_rd;

  regport_unlock #(
    .READS (UNLOCK_READS),
    .CW    (CNT_W)
  ) u_unlock (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mask_rd_i (mask_rd),
    .other_i   (other_acc),
    .armed_o   (armed),
    .cnt_o     (unlock_cnt)
  );

  // armed write goes to the hidden byte, mask untouched
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q   <= MASK_RST;
      hidden_q <= '0;
    end else if (mask_wr) begin
      if (armed) hidden_q <= bus_wdata_i;
      else       mask_q   <= bus_wdata_i;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (sel.kind)
      SEL_IDX:  rd_mux = bank_idx[sel.bank];
      SEL_DAT:  rd_mux = bank_dat[sel.bank];
      SEL_MASK: rd_mux = mask_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (acc_rd) begin
      rdata_q <= rd_mux;
    end
  end

  assign fmt          = depth_to_fmt(bank_tap[BK_SEQ][4:0]);
  assign bus_rdata_o  = rdata_q;
  assign pix_fmt_o    = fmt;
  assign hidden_fmt_o = hidden_q;
  assign pix_mask_o   = mask_q;
  assign fmt_ok_o     = (fmt != FMT_NONE) && (hidden_q == fmt_to_hidden(fmt));

endmodule

// File: rtl/regport_chk.sv
module regport_chk #(
  parameter int READS = 4,
  parameter int CW    = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          bus_en_i,
  input logic          bus_we_i,
  input logic [7:0]    bus_rdata_o,
  input logic [2:0]    pix_fmt_o,
  input logic [7:0]    hidden_fmt_o,
  input logic [7:0]    pix_mask_o,
  input logic          fmt_ok_o,
  input logic          mask_rd,
  input logic          mask_wr,
  input logic          armed,
  input logic [CW-1:0] unlock_cnt
);

  assert_cnt_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unlock_cnt <= CW'(READS));

  assert_arm_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_rd && unlock_cnt < CW'(READS)) |=> unlock_cnt == $past(unlock_cnt) + 1'b1);

  assert_hidden_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(hidden_fmt_o) |-> $past(mask_wr && armed));

  assert_mask_kept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_wr && armed) |=> $stable(pix_mask_o));

  assert_cancel_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_en_i && !mask_rd) |=> unlock_cnt == '0);

  assert_fmt_ok_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fmt_ok_o |-> pix_fmt_o != 3'd0);

  assert_rdata_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_en_i && !bus_we_i) |=> $stable(bus_rdata_o));

endmodule

bind disp_regport regport_chk #(
  .READS (UNLOCK_READS),
  .CW    (CNT_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bus_en_i     (bus_en_i),
  .bus_we_i     (bus_we_i),
  .bus_rdata_o  (bus_rdata_o),
  .pix_fmt_o    (pix_fmt_o),
  .hidden_fmt_o (hidden_fmt_o),
  .pix_mask_o   (pix_mask_o),
  .fmt_ok_o     (fmt_ok_o),
  .mask_rd      (mask_rd),
  .mask_wr      (mask_wr),
  .armed        (armed),
  .unlock_cnt   (unlock_cnt)
);

// File: tb/disp_regport_bench.sv
module disp_regport_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYCLES = 50000;
  localparam int SEQ_N = 32;
  localparam int GFX_N = 16;
  localparam int CRT_N = 64;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bus_en = 1'b0, bus_we = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata, hidden_fmt, pix_mask;
  logic [2:0] pix_fmt;
  logic       fmt_ok;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state
  int seq_m [SEQ_N];
  int gfx_m [GFX_N];
  int crt_m [CRT_N];
  int sidx, gidx, cidx, mask_m, hid_m, rd_m, cnt_m;

  always #(CLK_PERIOD/2) clk = ~clk;

  disp_regport u_disp_regport (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .bus_en_i     (bus_en),
    .bus_we_i     (bus_we),
    .bus_addr_i   (bus_addr),
    .bus_wdata_i  (bus_wdata),
    .bus_rdata_o  (bus_rdata),
    .pix_fmt_o    (pix_fmt),
    .hidden_fmt_o (hidden_fmt),
    .pix_mask_o   (pix_mask),
    .fmt_ok_o     (fmt_ok)
  );

  function automatic int fmt_exp(int code);
    case (code & 'h1F)
      'h11: return 1;
      'h17: return 2;
      'h15: return 3;
      'h19: return 4;
      default: return 0;
    endcase
  endfunction

  function automatic int ok_exp();
    int f = fmt_exp(seq_m[7]);
    if (f == 0) return 0;
    if (f == 1) return (hid_m == 'h00) ? 1 : 0;
    if (f == 2) return (hid_m == 'hC1) ? 1 : 0;
    return (hid_m == 'hC5) ? 1 : 0;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    foreach (seq_m[i]) seq_m[i] = 0;
    foreach (gfx_m[i]) gfx_m[i] = 0;
    foreach (crt_m[i]) crt_m[i] = 0;
    sidx = 0; gidx = 0; cidx = 0;
    mask_m = 'hFF; hid_m = 0; rd_m = 0; cnt_m = 0;
  endtask

  task automatic model_step(bit en, bit we, int addr, int wd);
    int v;
    if (!en) return;
    if (we) begin
      case (addr)
        'h04: sidx = wd;
        'h05: if (sidx < SEQ_N) seq_m[sidx] = wd;
        'h0E: gidx = wd;
        'h0F: if (gidx < GFX_N) gfx_m[gidx] = wd;
        'h14: cidx = wd;
        'h15: if (cidx < CRT_N) crt_m[cidx] = wd;
        'h06: if (cnt_m == 4) hid_m = wd; else mask_m = wd;
        default: ;
      endcase
      cnt_m = 0;
    end else begin
      case (addr)
        'h04: v = sidx;
        'h05: v = (sidx < SEQ_N) ? seq_m[sidx] : 0;
        'h0E: v = gidx;
        'h0F: v = (gidx < GFX_N) ? gfx_m[gidx] : 0;
        'h14: v = cidx;
        'h15: v = (cidx < CRT_N) ? crt_m[cidx] : 0;
        'h06: v = mask_m;
        default: v = 0;
      endcase
      rd_m = v;
      if (addr == 'h06) begin
        if (cnt_m < 4) cnt_m++;
      end else cnt_m = 0;
    end
  endtask

  task automatic compare_all(string tag);
    chk({tag, " rdata R13"}, bus_rdata, rd_m);
    chk({tag, " pix_fmt R10"}, pix_fmt, fmt_exp(seq_m[7]));
    chk({tag, " hidden R8"}, hidden_fmt, hid_m);
    chk({tag, " mask R7"}, pix_mask, mask_m);
    chk({tag, " fmt_ok R11"}, fmt_ok, ok_exp());
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic cyc(string tag, bit en, bit we, int addr, int wd);
    bus_en = en; bus_we = we; bus_addr = addr[4:0]; bus_wdata = wd[7:0];
    @(posedge clk);
    model_step(en, we, addr, wd);
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
    compare_all(tag);
  endtask

  task automatic wr(string tag, int addr, int wd);
    cyc(tag, 1'b1, 1'b1, addr, wd);
  endtask

  task automatic rd(string tag, int addr, int exp);
    cyc(tag, 1'b1, 1'b0, addr, 0);
    chk({tag, " read"}, bus_rdata, exp);
  endtask

  task automatic idle(string tag);
    cyc(tag, 1'b0, 1'b0, 0, 0);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (WDOG_CYCLES) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state while reset is held
    compare_all("R1 in reset");
    rst_ni = 1'b1;
    idle("R1 after release");
    rd("R1 seq index", 'h04, 'h00);
    rd("R1 seq data", 'h05, 'h00);
    rd("R1 crt index", 'h14, 'h00);
    rd("R1 mask", 'h06, 'hFF);
    chk("R1 hidden", hidden_fmt, 'h00);

    // R2: index latches
    wr("R2", 'h04, 'h07);
    rd("R2 seq idx", 'h04, 'h07);
    wr("R2", 'h14, 'h1B);
    rd("R2 crt idx", 'h14, 'h1B);
    wr("R2", 'h0E, 'hA5);
    rd("R2 gfx idx full byte", 'h0E, 'hA5);

    // R3 and R10: sequencer reg 7 depth codes
    wr("R3", 'h05, 'h11);
    rd("R3 seq rd", 'h05, 'h11);
    chk("R10 idx8", pix_fmt, 1);
    chk("R11 idx8 with hidden 0", fmt_ok, 1);
    wr("R10", 'h05, 'hF7);
    chk("R10 upper bits ignored", pix_fmt, 2);
    rd("R3 upper bits kept", 'h05, 'hF7);
    wr("R10", 'h05, 'h15);
    chk("R10 24bpp", pix_fmt, 3);
    wr("R10", 'h05, 'h19);
    chk("R10 32bpp", pix_fmt, 4);
    wr("R10", 'h05, 'h12);
    chk("R10 unknown", pix_fmt, 0);
    wr("R3", 'h04, 'h1F);
    wr("R3", 'h05, 'h3C);
    rd("R3 top seq reg", 'h05, 'h3C);

    // R4: CRT bank
    wr("R4", 'h14, 'h0C);
    wr("R4", 'h15, 'h5A);
    wr("R4", 'h14, 'h3F);
    wr("R4", 'h15, 'h81);
    wr("R4", 'h14, 'h0C);
    rd("R4 crt 0x0C", 'h15, 'h5A);
    wr("R4", 'h14, 'h3F);
    rd("R4 crt 0x3F", 'h15, 'h81);

    // R5: graphics bank
    wr("R5", 'h0E, 'h05);
    wr("R5", 'h0F, 'h40);
    wr("R5", 'h0E, 'h06);
    wr("R5", 'h0F, 'h01);
    rd("R5 gfx 6", 'h0F, 'h01);
    wr("R5", 'h0E, 'h05);
    rd("R5 gfx 5", 'h0F, 'h40);

    // R6: out-of-range index, no aliasing
    wr("R6", 'h14, 'h50);
    wr("R6", 'h15, 'h77);
    rd("R6 crt oob read", 'h15, 'h00);
    wr("R6", 'h14, 'h10);
    rd("R6 crt alias untouched", 'h15, 'h00);
    wr("R6", 'h0E, 'h10);
    wr("R6", 'h0F, 'hEE);
    rd("R6 gfx oob read", 'h0F, 'h00);
    wr("R6", 'h0E, 'h00);
    rd("R6 gfx alias untouched", 'h0F, 'h00);

    // R7: plain mask access
    wr("R7", 'h06, 'h3C);
    rd("R7 mask", 'h06, 'h3C);

    // R8: unlock after four reads, hidden write, mask kept
    wr("R8", 'h04, 'h07);
    wr("R8", 'h05, 'h17);
    for (int i = 0; i < 4; i++) rd("R8 unlock read", 'h06, 'h3C);
    wr("R8", 'h06, 'hC1);
    chk("R8 hidden written", hidden_fmt, 'hC1);
    chk("R8 mask kept", pix_mask, 'h3C);
    chk("R11 565 consistent", fmt_ok, 1);
    // R8: saturation with extra reads
    for (int i = 0; i < 7; i++) rd("R8 extra read", 'h06, 'h3C);
    wr("R8", 'h06, 'hC5);
    chk("R8 saturated hidden", hidden_fmt, 'hC5);
    chk("R11 565 vs C5", fmt_ok, 0);

    // R9: cancellations
    for (int i = 0; i < 3; i++) rd("R9 short run", 'h06, 'h3C);
    wr("R9", 'h06, 'h99);
    chk("R9 short run goes to mask", pix_mask, 'h99);
    chk("R9 hidden unchanged", hidden_fmt, 'hC5);
    for (int i = 0; i < 4; i++) rd("R9 run", 'h06, 'h99);
    rd("R9 interleaved read", 'h04, 'h07);
    wr("R9", 'h06, 'h55);
    chk("R9 interleave cancels", pix_mask, 'h55);
    for (int i = 0; i < 4; i++) rd("R9 run", 'h06, 'h55);
    wr("R9", 'h06, 'h00);
    wr("R9", 'h06, 'h66);
    chk("R9 armed write consumed", pix_mask, 'h66);
    chk("R9 hidden from first write", hidden_fmt, 'h00);
    for (int i = 0; i < 4; i++) rd("R9 run", 'h06, 'h66);
    rd("R9 unmapped read", 'h00, 'h00);
    wr("R9", 'h06, 'h24);
    chk("R9 unmapped cancels", pix_mask, 'h24);
    for (int i = 0; i < 4; i++) rd("R9 run", 'h06, 'h24);
    idle("R9 idle keeps arm");
    wr("R9", 'h06, 'hC1);
    chk("R9 idle does not cancel", hidden_fmt, 'hC1);

    // R12: unmapped offsets
    wr("R12", 'h00, 'hFF);
    wr("R12", 'h1F, 'hFF);
    wr("R12", 'h07, 'hFF);
    rd("R12 read 0x1F", 'h1F, 'h00);
    rd("R12 read 0x10", 'h10, 'h00);
    rd("R12 mask intact", 'h06, 'h24);

    // R13: rdata holds through writes and idles
    rd("R13 load", 'h05, 'h17);
    wr("R13", 'h0E, 'h03);
    idle("R13");
    chk("R13 held", bus_rdata, 'h17);

    // mixed traffic, every cycle against the model
    for (int n = 0; n < 3000; n++) begin
      int pick = $urandom_range(0, 11);
      int a;
      bit w = $urandom_range(0, 1);
      int d = $urandom_range(0, 255);
      case (pick)
        0: a = 'h04; 1: a = 'h05; 2: a = 'h0E; 3: a = 'h0F;
        4: a = 'h14; 5: a = 'h15; 6: a = 'h00;
        default: begin a = 'h06; w = (pick == 11); end
      endcase
      if ((a == 'h04) && (d > 40) && pick[0]) d = 7;
      cyc("R3 R4 R5 R8 R9 mixed", $urandom_range(0, 7) != 0, w, a, d);
    end

    summary();
  end

endmodule